// File: doc/BRIEF.md
# Dual-Encoder Speed Error Unit

This block compares the speeds of two shafts that each carry a quadrature encoder. Each channel decodes its two phase signals at four counts per encoder line, counting up or down with the direction of rotation. A programmable window timer splits time into fixed periods. At the end of each period, each channel's signed count is multiplied by that channel's weight. The weighted counts are subtracted, and the difference is divided by a scaler. The result is a saturated signed 16-bit speed-error word together with a one-cycle valid strobe.

The weights let encoders with different line counts, or shafts behind different gear or belt stages, be compared on one scale. In a speed-follower loop the error word typically feeds a PI(D) stage that trims the follower's speed reference. In a phase-follower loop it feeds an integrator first. Weight and scaler inputs are sampled once per window, at the window's closing boundary. This means a result always reflects one consistent set of values.

Top module: `enc_speed_err`

## Requirements
- R1: A channel's phase pair {A,B} stepping through 00→01→11→10→00 adds +1 to that window's count on every step; the reverse order adds −1.
- R2: A step where both phase bits change together is not counted, and it sets that channel's bit of `quad_fault` (bit 0 for channel 0, bit 1 for channel 1). The bit then stays set until reset.
- R3: A window lasts `win_len` clock cycles, and a value of 0 acts as 1. Exactly one `err_valid` pulse is produced per window, so consecutive pulses are `win_len` cycles apart.
- R4: The result equals (count0 × ratio0 − count1 × ratio1) / scaler. Counts are signed and the ratios and scaler are unsigned.
- R5: The division truncates toward zero (7/2 gives 3, −7/2 gives −3).
- R6: `err_out` is clamped to the range −32767…+32767 and never shows −32768.
- R7: Each product and the difference saturate to ±2147483647. `ovf` accompanies each result and is 1 exactly when one of those intermediate values saturated. Clamping at the output alone does not set it.
- R8: A scaler of 0 divides by 1.
- R9: The ratio and scaler values present at the closing boundary of a window are the ones applied to that window's result, even if they changed during the window.
- R10: While reset is asserted, `err_out` is 0, and `err_valid`, `ovf` and `quad_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch0_a | input | 1 | Channel 0 phase A |
| ch0_b | input | 1 | Channel 0 phase B |
| ch1_a | input | 1 | Channel 1 phase A |
| ch1_b | input | 1 | Channel 1 phase B |
| ratio0 | input | 24 | Channel 0 weight, unsigned |
| ratio1 | input | 24 | Channel 1 weight, unsigned |
| scaler | input | 16 | Divisor of the difference, unsigned, 0 acts as 1 |
| win_len | input | 24 | Window length in clock cycles |
| err_out | output | 16 | Signed speed error, held between results |
| err_valid | output | 1 | One-cycle strobe when a new `err_out` is ready |
| quad_fault | output | 2 | Sticky per-channel illegal-step flags |
| ovf | output | 1 | Intermediate saturation flag for the current result |

## Verification
The hardest case to reach is saturation of the 32-bit intermediate values. A realistic stream of encoder edges cannot drive a count high enough on its own, so the stimulus pairs a few hundred edges with weights near the top of the 24-bit range. To push the difference past its limit while each product stays in range, it runs the two channels in opposite directions. The bench places every edge burst directly after a result strobe. Every edge therefore lands inside a known window, well clear of the boundary, and the expected result of each window is fully determined.

// File: rtl/enc_err_pkg.sv
package enc_err_pkg;

    localparam longint ACC_MAX = 64'sd2147483647;
    localparam int     ERR_MAX = 32767;

    function automatic logic signed [31:0] sat_acc(input longint v);
        if (v > ACC_MAX)       return 32'sd2147483647;
        else if (v < -ACC_MAX) return -32'sd2147483647;
        else                   return 32'(v);
    endfunction

    function automatic logic acc_hits_limit(input longint v);
        return (v > ACC_MAX) || (v < -ACC_MAX);
    endfunction

    function automatic logic signed [15:0] clamp_err(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'sd32767;
        else if (v < -32'sd32767) return -16'sd32767;
        else                      return v[15:0];
    endfunction

endpackage

// File: rtl/enc_quad_chan.sv
module enc_quad_chan
    import enc_err_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_i,
    input  logic                    b_i,
    input  logic                    tick_i,
    output logic signed [CNT_W-1:0] cap_o,
    output logic                    fault_o
);

    typedef struct packed {
        logic [1:0]              sy1;
        logic [1:0]              sy2;
        logic [1:0]              prv;
        logic signed [CNT_W-1:0] cnt;
        logic signed [CNT_W-1:0] cap;
        logic                    fault;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic step_up, step_dn, jump;
    logic signed [CNT_W-1:0] delta;

    always_comb begin
        st_d    = st_q;
        // forward order 00->01->11->10: next = {prev[0], ~prev[1]}
        step_up = (st_q.sy2 == {st_q.prv[0], ~st_q.prv[1]});
        step_dn = (st_q.prv == {st_q.sy2[0], ~st_q.sy2[1]});
        jump    = ((st_q.sy2 ^ st_q.prv) == 2'b11);
        if (step_up)      delta = CNT_W'(1);
        else if (step_dn) delta = '1;
        else              delta = '0;

        st_d.sy1 = {a_i, b_i};
        st_d.sy2 = st_q.sy1;
        st_d.prv = st_q.sy2;
        if (jump) st_d.fault = 1'b1;

        if (tick_i) begin
            st_d.cap = st_q.cnt + delta;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + delta;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o   = st_q.cap;
    assign fault_o = st_q.fault;

    assert_fault_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |=> st_q.fault);

endmodule

// File: rtl/enc_win_timer.sv
module enc_win_timer #(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] len_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic             tick;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic [LEN_W-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        last_idx = (len_i == '0) ? '0 : len_i - LEN_W'(1);
        if (st_q.cnt >= last_idx) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + LEN_W'(1);
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> (!st_q.tick || len_i <= LEN_W'(1)));

endmodule

// File: rtl/enc_err_calc.sv
module enc_err_calc
    import enc_err_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 24,
    parameter int SCALE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic signed [CNT_W-1:0] cap0_i,
    input  logic signed [CNT_W-1:0] cap1_i,
    input  logic [RATIO_W-1:0]      ratio0_i,
    input  logic [RATIO_W-1:0]      ratio1_i,
    input  logic [SCALE_W-1:0]      scaler_i,
    output logic signed [15:0]      err_o,
    output logic                    valid_o,
    output logic                    ovf_o
);

    typedef struct packed {
        logic                  v0;
        logic [RATIO_W-1:0]    r0;
        logic [RATIO_W-1:0]    r1;
        logic [SCALE_W-1:0]    sc;
        logic                  va;
        logic signed [31:0]    p0;
        logic signed [31:0]    p1;
        logic                  ova;
        logic                  vb;
        logic signed [31:0]    dif;
        logic                  ovb;
        logic                  vc;
        logic signed [15:0]    err;
        logic                  ovf;
    } calc_st_t;

    calc_st_t st_d, st_q;
    longint prod0, prod1, diff_w;
    logic signed [31:0] sc_w, quot;

    always_comb begin
        st_d   = st_q;
        prod0  = longint'(cap0_i) * longint'(st_q.r0);
        prod1  = longint'(cap1_i) * longint'(st_q.r1);
        diff_w = longint'($signed(st_q.p0)) - longint'($signed(st_q.p1));
        sc_w   = {{(32-SCALE_W){1'b0}}, st_q.sc};
        quot   = $signed(st_q.dif) / sc_w;

        // stage 0: freeze weights at the window boundary
        st_d.v0 = tick_i;
        if (tick_i) begin
            st_d.r0 = ratio0_i;
            st_d.r1 = ratio1_i;
            st_d.sc = (scaler_i == '0) ? SCALE_W'(1) : scaler_i;
        end
        // stage A: weighted counts
        st_d.va = st_q.v0;
        if (st_q.v0) begin
            st_d.p0  = sat_acc(prod0);
            st_d.p1  = sat_acc(prod1);
            st_d.ova = acc_hits_limit(prod0) || acc_hits_limit(prod1);
        end
        // stage B: difference
        st_d.vb = st_q.va;
        if (st_q.va) begin
            st_d.dif = sat_acc(diff_w);
            st_d.ovb = st_q.ova || acc_hits_limit(diff_w);
        end
        // stage C: divide and clamp
        st_d.vc = st_q.vb;
        if (st_q.vb) begin
            st_d.err = clamp_err(quot);
            st_d.ovf = st_q.ovb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o   = st_q.err;
    assign valid_o = st_q.vc;
    assign ovf_o   = st_q.ovf;

    assert_out_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vc |-> (st_q.err != 16'sh8000));

    assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vb |=> ($stable(st_q.err) && $stable(st_q.ovf)));

endmodule

// File: rtl/enc_speed_err.sv
module enc_speed_err
    import enc_err_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 24,
    parameter int SCALE_W = 16,
    parameter int LEN_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ch0_a,
    input  logic               ch0_b,
    input  logic               ch1_a,
    input  logic               ch1_b,
    input  logic [RATIO_W-1:0] ratio0,
    input  logic [RATIO_W-1:0] ratio1,
    input  logic [SCALE_W-1:0] scaler,
    input  logic [LEN_W-1:0]   win_len,
    output logic signed [15:0] err_out,
    output logic               err_valid,
    output logic [1:0]         quad_fault,
    output logic               ovf
);

    localparam int N_CH = 2;

    logic [N_CH-1:0]         ph_a, ph_b;
    logic signed [CNT_W-1:0] cap [N_CH];
    logic                    tick;

    assign ph_a = {ch1_a, ch0_a};
    assign ph_b = {ch1_b, ch0_b};

    enc_win_timer #(.LEN_W(LEN_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .len_i  (win_len),
        .tick_o (tick)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        enc_quad_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_i     (ph_a[g]),
            .b_i     (ph_b[g]),
            .tick_i  (tick),
            .cap_o   (cap[g]),
            .fault_o (quad_fault[g])
        );
    end

    enc_err_calc #(
        .CNT_W   (CNT_W),
        .RATIO_W (RATIO_W),
        .SCALE_W (SCALE_W)
    ) u_calc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .cap0_i   (cap[0]),
        .cap1_i   (cap[1]),
        .ratio0_i (ratio0),
        .ratio1_i (ratio1),
        .scaler_i (scaler),
        .err_o    (err_out),
        .valid_o  (err_valid),
        .ovf_o    (ovf)
    );

endmodule

// File: tb/enc_speed_err_bench.sv
module enc_speed_err_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic ch0_a, ch0_b, ch1_a, ch1_b;
    logic [23:0] ratio0, ratio1, win_len;
    logic [15:0] scaler;
    logic signed [15:0] err_out;
    logic err_valid, ovf;
    logic [1:0] quad_fault;

    enc_speed_err u_enc_speed_err (
        .clk(clk), .rst_n(rst_n),
        .ch0_a(ch0_a), .ch0_b(ch0_b), .ch1_a(ch1_a), .ch1_b(ch1_b),
        .ratio0(ratio0), .ratio1(ratio1), .scaler(scaler), .win_len(win_len),
        .err_out(err_out), .err_valid(err_valid), .quad_fault(quad_fault), .ovf(ovf)
    );

    typedef struct {
        longint err;
        bit     ovf;
        string  req;
    } exp_t;

    exp_t   sb[$];
    exp_t   cur;
    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint last_v = 0;
    longint prev_v = 0;
    int     ph [2];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per result strobe
    always @(negedge clk) begin
        if (rst_n && err_valid) begin
            prev_v = last_v;
            last_v = cyc;
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected result", err_out, 0);
            end else begin
                cur = sb.pop_front();
                chk(longint'(err_out) == cur.err, cur.req, err_out, cur.err);
                chk(ovf == cur.ovf, {cur.req, " ovf"}, ovf, cur.ovf);
            end
        end
    end

    function automatic longint sat(input longint v, inout bit o);
        if (v > 64'sd2147483647) begin o = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483647) begin o = 1'b1; return -64'sd2147483647; end
        return v;
    endfunction

    function automatic exp_t model(input longint n0, input longint n1, input longint r0,
                                   input longint r1, input longint sc, input string req);
        exp_t e;
        bit o = 1'b0;
        longint p0, p1, d, q;
        p0 = sat(n0 * r0, o);
        p1 = sat(n1 * r1, o);
        d  = sat(p0 - p1, o);
        q  = d / ((sc == 0) ? 64'sd1 : sc);
        if (q > 32767) q = 32767;
        if (q < -32767) q = -32767;
        e.err = q;
        e.ovf = o;
        e.req = req;
        return e;
    endfunction

    function automatic logic [1:0] code(input int i);
        case (i)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic apply_pins();
        {ch0_a, ch0_b} = code(ph[0]);
        {ch1_a, ch1_b} = code(ph[1]);
    endtask

    task automatic run_steps(input int n0, input int n1);
        int m = (iabs(n0) > iabs(n1)) ? iabs(n0) : iabs(n1);
        for (int k = 0; k < m; k++) begin
            if (k < iabs(n0)) ph[0] = (ph[0] + ((n0 < 0) ? 3 : 1)) % 4;
            if (k < iabs(n1)) ph[1] = (ph[1] + ((n1 < 0) ? 3 : 1)) % 4;
            apply_pins();
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!err_valid) @(negedge clk);
        @(negedge clk);
    endtask

    // driver: one window of edges, expected item pushed before the strobe
    task automatic window(input int n0, input int n1, input longint r0, input longint r1,
                          input longint sc, input string req);
        ratio0 = 24'(r0);
        ratio1 = 24'(r1);
        scaler = 16'(sc);
        run_steps(n0, n1);
        sb.push_back(model(n0, n1, r0, r1, sc, req));
        wait_valid();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        ph[0] = 0;
        ph[1] = 0;
        apply_pins();
        ratio0 = 24'd1; ratio1 = 24'd1; scaler = 16'd1; win_len = 24'd600;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(err_out == 16'sd0, "R10 err_out in reset", err_out, 0);
        chk(err_valid == 1'b0, "R10 err_valid in reset", err_valid, 0);
        chk(ovf == 1'b0, "R10 ovf in reset", ovf, 0);
        chk(quad_fault == 2'b00, "R10 quad_fault in reset", quad_fault, 0);
        sb.push_back(model(0, 0, 1, 1, 1, "R4 idle window"));
        rst_n = 1'b1;
        wait_valid();

        window(10, 4, 3, 5, 1, "R1 R4 forward weighted difference");
        window(-6, 0, 1, 1, 1, "R1 reverse rotation");
        window(0, -9, 2, 3, 1, "R1 reverse on channel 1");
        window(7, 0, 1, 1, 2, "R5 positive truncation");
        window(0, 7, 1, 1, 2, "R5 negative truncation");
        window(5, 2, 1, 1, 0, "R8 zero scaler");
        window(200, 0, 1000, 1, 1, "R6 positive clamp");
        window(0, 200, 1, 1000, 1, "R6 negative clamp");
        window(100, 0, 16000000, 1, 65535, "R7 large product in range");
        window(150, 0, 16000000, 1, 1, "R7 product saturates");
        window(100, -100, 16000000, 16000000, 65535, "R7 difference saturates");
        window(-100, 100, 16000000, 16000000, 3, "R7 negative difference saturates");

        // R9: weight changed late in the window applies to that window
        ratio0 = 24'd1; ratio1 = 24'd1; scaler = 16'd1;
        run_steps(20, 5);
        ratio0 = 24'd4; scaler = 16'd3;
        sb.push_back(model(20, 5, 4, 1, 3, "R9 boundary sampling"));
        wait_valid();

        // R2: illegal jump on channel 1 is not counted and latches the flag
        ratio0 = 24'd1; ratio1 = 24'd1; scaler = 16'd1;
        ph[1] = (ph[1] + 2) % 4;
        apply_pins();
        repeat (4) @(negedge clk);
        chk(quad_fault == 2'b10, "R2 fault flag on channel 1", quad_fault, 2);
        run_steps(3, 0);
        sb.push_back(model(3, 0, 1, 1, 1, "R2 jump not counted"));
        wait_valid();
        chk(quad_fault == 2'b10, "R2 fault flag sticky", quad_fault, 2);

        // R3: window length change and spacing of strobes
        win_len = 24'd300;
        window(0, 0, 1, 1, 1, "R3 window after length change");
        window(2, 1, 1, 1, 1, "R3 second short window");
        chk((last_v - prev_v) == 300, "R3 strobe spacing", last_v - prev_v, 300);

        finish_run();
    end

endmodule